// File: doc/BRIEF.md
# Strap-Configured Management Register Bridge

This block is the slave end of a register-level management bus for a device that carries 32 internal banks, each holding 32 registers of 16 bits. A host reaches it through a simple request port: a 5-bit bus address, a 5-bit register number, a write strobe and 16-bit write data. Read data comes back registered, one clock after the read request.

Four strap inputs set the device's bus address as bits 4:1, with bit 0 fixed at zero. When all straps are low, the block works as the only device on the bus. Each bus address then selects the bank with the same number, and accesses take effect at once. When any strap is high, the block shares the bus with other devices. It then answers only at its own strapped address and exposes just two registers there, a command word and a data word. The host loads the data word, then writes a command with the busy flag set. After a fixed internal latency the access completes and busy clears.

Top module: `mgmt_bridge`

## Requirements
- R1: The own address is {strap_i, 1'b0}. strap_i == 0 selects direct mode, and any other value selects shared mode.
- R2: In direct mode, a write stores wdata_i into bank addr_i, register reg_i. A read loads rdata_o on the next edge with that register's content. rdata_o holds its value in every cycle that carries no read request.
- R3: In shared mode, reads at any address other than the own address return 16'hFFFF. Writes there change nothing.
- R4: In shared mode at the own address, register numbers 2 to 31 read as 16'hFFFF. Writes to them change nothing.
- R5: Register 0 in shared mode is the command word. Bit 15 is busy and bit 12 selects the short frame format. Bits 11:10 hold the opcode, 01 for write and 10 for read. Bits 9:5 hold the bank and bits 4:0 the register. A read of register 0 returns {busy, 2'b00, bits 12:0 of the last accepted command}.
- R6: A command is accepted when it is written with bit 15 set, bit 12 set and a valid opcode while busy is clear. Busy then reads 1 for exactly ACC_LAT cycles after the accepting edge and 0 afterwards.
- R7: An accepted write command stores the data word into the selected bank register when it completes.
- R8: An accepted read command loads the data word (register 1) with the selected bank register when it completes.
- R9: A command written with bit 15 clear, bit 12 clear or opcode 00/11 is ignored. Busy stays 0 and the readback fields keep their values.
- R10: While busy is set, writes to the command word and to the data word are discarded.
- R11: After reset, rdata_o, busy, the command fields, the data word and all bank registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 4 | Strapped address bits 4:1 |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Bus address |
| reg_i | input | 5 | Register number |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |

## Verification
The assertions take the straps as static between resets. A change of mode in the middle of an access has no defined meaning. The bench changes strap_i only while rst_ni is low, running one phase each in direct mode, at a low strapped address and at the highest one. Within each phase the requests stay freely mixed, and that mix includes writes that collide with a busy access.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;
  localparam int BUSY_BIT = 15;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  // Command fields held after acceptance (word bits 12:0)
  typedef struct packed {
    logic              c22;
    logic [1:0]        op;
    logic [ADDR_W-1:0] dev;
    logic [REG_W-1:0]  rnum;
  } cmd_t;
endpackage

// File: rtl/mgmt_bank_array.sv
module mgmt_bank_array #(
  parameter int BANK_W = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wbank_i,
  input  logic [REG_W-1:0]  wreg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] rbank_i,
  input  logic [REG_W-1:0]  rreg_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = BANK_W + REG_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  widx, ridx;

  assign widx    = {wbank_i, wreg_i};
  assign ridx    = {rbank_i, rreg_i};
  assign rdata_o = mem_q[ridx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx] <= wdata_i;
    end
  end

  assert_bank_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(widx)] == $past(wdata_i));
endmodule

// File: rtl/mgmt_indirect_ctl.sv
module mgmt_indirect_ctl
  import mgmt_bridge_pkg::*;
#(
  parameter int ACC_LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bank_rdata_i,
  output logic              busy_o,
  output cmd_t              cmd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bank_we_o
);
  localparam int CNT_W = $clog2(ACC_LAT + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  cmd_t             cmd_q;
  logic [DATA_W-1:0] data_q;
  logic valid_fmt, accept, done;

  assign valid_fmt = wdata_i[12] && (wdata_i[11:10] == OP_WR || wdata_i[11:10] == OP_RD);
  assign accept    = cmd_wr_i && !busy_q && wdata_i[BUSY_BIT] && valid_fmt;
  assign done      = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
    end else if (accept) begin
      cmd_q  <= cmd_t'(wdata_i[12:0]);
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(ACC_LAT);
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (done) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         data_q <= '0;
    else if (data_wr_i && !busy_q)       data_q <= wdata_i;
    else if (done && cmd_q.op == OP_RD)  data_q <= bank_rdata_i;
  end

  assign busy_o    = busy_q;
  assign cmd_o     = cmd_q;
  assign data_o    = data_q;
  assign bank_we_o = done && (cmd_q.op == OP_WR);

  assert_busy_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(cmd_wr_i && wdata_i[BUSY_BIT] && wdata_i[12]));
  assert_bad_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && cmd_wr_i && !valid_fmt) |=> !busy_q && $stable(cmd_q));
  assert_cmd_discard_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_wr_i) |=> $stable(cmd_q));
  assert_data_discard_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done && data_wr_i) |=> $stable(data_q));
endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge
  import mgmt_bridge_pkg::*;
#(
  parameter int ACC_LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        strap_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] own_addr;
  logic shared, hit, cmd_wr, data_wr, direct_wr;
  logic busy, eng_we;
  cmd_t cmd;
  logic [DATA_W-1:0] data_word, bank_rdata, rdata_d, rdata_q;
  logic [ADDR_W-1:0] bank_sel;
  logic [REG_W-1:0]  reg_sel;

  assign own_addr  = {strap_i, 1'b0};
  assign shared    = |strap_i;
  assign hit       = shared && req_i && (addr_i == own_addr);
  assign cmd_wr    = hit && we_i && (reg_i == REG_W'(0));
  assign data_wr   = hit && we_i && (reg_i == REG_W'(1));
  assign direct_wr = !shared && req_i && we_i;

  assign bank_sel = shared ? cmd.dev  : addr_i;
  assign reg_sel  = shared ? cmd.rnum : reg_i;

  mgmt_bank_array #(.BANK_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_banks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (direct_wr || eng_we),
    .wbank_i (bank_sel),
    .wreg_i  (reg_sel),
    .wdata_i (shared ? data_word : wdata_i),
    .rbank_i (bank_sel),
    .rreg_i  (reg_sel),
    .rdata_o (bank_rdata)
  );

  mgmt_indirect_ctl #(.ACC_LAT(ACC_LAT)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (cmd_wr),
    .data_wr_i    (data_wr),
    .wdata_i      (wdata_i),
    .bank_rdata_i (bank_rdata),
    .busy_o       (busy),
    .cmd_o        (cmd),
    .data_o       (data_word),
    .bank_we_o    (eng_we)
  );

  always_comb begin
    if (!shared)                        rdata_d = bank_rdata;
    else if (hit && reg_i == REG_W'(0)) rdata_d = {busy, 2'b00, cmd};
    else if (hit && reg_i == REG_W'(1)) rdata_d = data_word;
    else                                rdata_d = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  assert_foreign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared && req_i && !we_i && addr_i != own_addr) |=> rdata_o == '1);
  assert_hole_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !we_i && reg_i > REG_W'(1)) |=> rdata_o == '1);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
  assert_strap_static_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(strap_i));
endmodule

// File: tb/mgmt_bridge_test.sv
module mgmt_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap = 4'd0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0, rnum = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0, fails = 0;

  logic [15:0] m_mem [1024];
  bit          m_busy;
  int          m_cnt;
  logic [12:0] m_cmd;
  logic [15:0] m_data, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_bridge #(.ACC_LAT(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .req_i(req), .we_i(we),
    .addr_i(addr), .reg_i(rnum), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic compare(input string tag);
    checks++;
    if (rdata !== m_rd) begin
      fails++;
      $display("FAIL %s: rdata actual %h expected %h (t=%0t)", tag, rdata, m_rd, $time);
    end
  endtask

  task automatic step(input bit r, input bit w, input logic [4:0] a,
                      input logic [4:0] g, input logic [15:0] d, input string tag);
    bit shared, pre_busy;
    logic [4:0] own;
    int idx;
    @(negedge clk);
    req = r; we = w; addr = a; rnum = g; wdata = d;
    shared = (strap != 0);
    own = {strap, 1'b0};
    pre_busy = m_busy;
    if (r && !w) begin
      if (!shared)                 m_rd = m_mem[a*32 + g];
      else if (a == own && g == 0) m_rd = {m_busy, 2'b00, m_cmd};
      else if (a == own && g == 1) m_rd = m_data;
      else                         m_rd = 16'hFFFF;
    end
    if (r && w) begin
      if (!shared) m_mem[a*32 + g] = d;
      else if (a == own && !pre_busy) begin
        if (g == 0 && d[15] && d[12] && (d[11:10] == 2'b01 || d[11:10] == 2'b10)) begin
          m_cmd = d[12:0]; m_busy = 1; m_cnt = LAT;
        end else if (g == 1) m_data = d;
      end
    end
    if (pre_busy) begin
      if (m_cnt == 1) begin
        idx = int'(m_cmd[9:5]) * 32 + int'(m_cmd[4:0]);
        if (m_cmd[11:10] == 2'b01) m_mem[idx] = m_data;
        else                       m_data = m_mem[idx];
        m_busy = 0;
      end
      m_cnt--;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare(tag);
  endtask

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk);
    rst_n = 1'b0; req = 0; we = 0; strap = s;
    for (int i = 0; i < 1024; i++) m_mem[i] = '0;
    m_busy = 0; m_cnt = 0; m_cmd = '0; m_data = '0; m_rd = '0;
    repeat (2) @(negedge clk);
    compare("R11");
    rst_n = 1'b1;
  endtask

  task automatic wait_busy(input logic [4:0] own, input string tag);
    for (int i = 0; i < LAT + 1; i++) step(1, 0, own, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // Direct mode
    do_reset(4'd0);
    step(1, 0, 5'd3, 5'd7, 0, "R11");
    for (int i = 0; i < 32; i++) step(1, 1, 5'(i), 5'((i*7) % 32), 16'(i*1000 + 5), "R2");
    for (int i = 0; i < 32; i++) step(1, 0, 5'(i), 5'((i*7) % 32), 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    step(1, 1, 5'd9, 5'd9, 16'h1234, "R2");
    step(0, 1, 5'd9, 5'd9, 16'h5555, "R2");
    step(1, 0, 5'd9, 5'd9, 0, "R2");
    step(1, 0, 5'd10, 5'd0, 0, "R1");

    // Shared mode, own address 10
    do_reset(4'd5);
    step(1, 0, 5'd10, 5'd0, 0, "R11");
    step(1, 0, 5'd10, 5'd1, 0, "R11");
    step(1, 1, 5'd10, 5'd1, 16'hBEEF, "R7");
    step(1, 1, 5'd10, 5'd0, 16'h9400 | (3 << 5) | 9, "R6");
    step(1, 1, 5'd10, 5'd0, 16'h9800 | (4 << 5) | 2, "R10");
    step(1, 1, 5'd10, 5'd1, 16'h0BAD, "R10");
    wait_busy(5'd10, "R6");
    step(1, 0, 5'd10, 5'd1, 0, "R10");
    step(1, 1, 5'd10, 5'd1, 16'h0000, "R8");
    step(1, 1, 5'd10, 5'd0, 16'h9800 | (3 << 5) | 9, "R8");
    wait_busy(5'd10, "R5");
    step(1, 0, 5'd10, 5'd1, 0, "R8");
    step(1, 1, 5'd10, 5'd1, 16'hA5A5, "R7");
    step(1, 1, 5'd10, 5'd0, 16'h9400 | (31 << 5) | 31, "R7");
    wait_busy(5'd10, "R6");
    step(1, 1, 5'd10, 5'd1, 16'h0000, "R8");
    step(1, 1, 5'd10, 5'd0, 16'h9800 | (31 << 5) | 31, "R8");
    wait_busy(5'd10, "R8");
    step(1, 0, 5'd10, 5'd1, 0, "R8");
    step(1, 1, 5'd10, 5'd0, 16'h8800 | (1 << 5) | 1, "R9");
    step(1, 0, 5'd10, 5'd0, 0, "R9");
    step(1, 1, 5'd10, 5'd0, 16'h9C00 | (1 << 5) | 1, "R9");
    step(1, 0, 5'd10, 5'd0, 0, "R9");
    step(1, 1, 5'd10, 5'd0, 16'h9000 | (1 << 5) | 1, "R9");
    step(1, 0, 5'd10, 5'd0, 0, "R9");
    step(1, 1, 5'd10, 5'd0, 16'h1800 | (1 << 5) | 1, "R9");
    step(1, 0, 5'd10, 5'd0, 0, "R9");
    step(1, 1, 5'd11, 5'd1, 16'h7777, "R3");
    step(1, 1, 5'd0, 5'd1, 16'h6666, "R3");
    step(1, 0, 5'd11, 5'd1, 0, "R3");
    step(1, 0, 5'd0, 5'd0, 0, "R3");
    step(1, 0, 5'd10, 5'd1, 0, "R3");
    step(1, 1, 5'd10, 5'd2, 16'h4444, "R4");
    step(1, 1, 5'd10, 5'd31, 16'h9400, "R4");
    step(1, 0, 5'd10, 5'd2, 0, "R4");
    step(1, 0, 5'd10, 5'd31, 0, "R4");
    step(1, 0, 5'd10, 5'd1, 0, "R4");
    step(1, 0, 5'd10, 5'd0, 0, "R5");

    // Shared mode, own address 30
    do_reset(4'hF);
    step(1, 0, 5'd10, 5'd0, 0, "R1");
    step(1, 1, 5'd30, 5'd1, 16'hC3C3, "R1");
    step(1, 1, 5'd30, 5'd0, 16'h9400, "R7");
    wait_busy(5'd30, "R6");
    step(1, 1, 5'd30, 5'd1, 16'h0000, "R8");
    step(1, 1, 5'd30, 5'd0, 16'h9800, "R8");
    wait_busy(5'd30, "R8");
    step(1, 0, 5'd30, 5'd1, 0, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule